// File: doc/BRIEF.md
# Dual-Rail Power-Good Reset Generator

This block turns the threshold comparator bits of two regulated supply rails into one active-low reset flag per rail. Each rail has two comparator inputs. One says the rail is above its upper (entry) threshold, near 94% of nominal. The other says it is below its lower (exit) threshold, near 90% of nominal. The reset flag is released only after the upper comparator has stayed high without a break for a long entry delay. It is pulled low again only after the lower comparator has stayed high without a break for a short exit delay. Any break in the qualifying input restarts that timer, so glitches shorter than a delay never change the flag.

Rail 1 has fixed delays set by parameters. Rail 2 takes its delays from one programmable value held in a small register. That value is the exit delay in microseconds, and the entry delay is the same value times a fixed ratio. Both Rail 2 delays therefore scale together. Every delay has a floor of a minimum exit time, so it cannot be set too short. Delays are counted in clock cycles derived from the clock-period parameter. Each rail also has an enable, and a disabled rail is held in reset.

Top module: `pgr_reset_gen`

## Requirements
- R1: While `rst_i` is high, or while a rail's enable is low, that rail's `rst_n_o` bit is 0. Its timer is cleared, so after re-enabling, the full entry delay is needed again.
- R2: Rail 1 (bit 0) releases `rst_n_o[0]` to 1 after the edge on which `above_hi_i[0]` has been sampled high on E1 consecutive clock edges. E1 = R1_ENTRY_US × 1000 / CLK_PERIOD_NS, which is 2000 cycles by default. After E1−1 such edges, the bit is still 0.
- R3: If `above_hi_i` drops for even one sampled edge before its delay completes, the entry count restarts from zero.
- R4: A good rail 1 drives `rst_n_o[0]` to 0 after `below_lo_i[0]` has been sampled high on X1 consecutive edges, where X1 is 25 cycles by default. A run of X1−1 edges leaves the bit at 1.
- R5: If `below_lo_i` drops for one sampled edge before its delay completes, the exit count restarts from zero.
- R6: Rail 2 (bit 1) uses the register value P, which resets to 25. When `cfg_we_i` is high on an edge, that edge loads `cfg_val_i` into P, and the new value applies from the next edge. The exit delay is P µs and the entry delay is P × R2_RATIO µs, with R2_RATIO defaulting to 8000.
- R7: Any delay that would be shorter than MIN_EXIT_US (10 µs by default) is raised to MIN_EXIT_US. This includes both delays of rail 2 when P is 0.
- R8: The two rails are independent. A rail's inputs, delays and enable never change the other rail's output.
- R9: If an enable goes low on the same edge at which that rail's entry delay would complete, the rail stays out of power-good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rail_en_i | input | 2 | Per-rail enable, bit 0 = rail 1 |
| above_hi_i | input | 2 | Rail above upper (entry) threshold |
| below_lo_i | input | 2 | Rail below lower (exit) threshold |
| cfg_we_i | input | 1 | Write strobe for the rail 2 delay value |
| cfg_val_i | input | CFG_W | Rail 2 delay value P (exit delay in µs) |
| rst_n_o | output | 2 | Active-low reset per rail, 1 = power good |

## Verification
The interaction that matters most is an enable falling on the same edge at which that rail's entry count reaches its limit. Here the timer expiry and the forced clear meet in one cycle. The bench provokes this by holding the upper comparator high for exactly one cycle short of the entry delay. It then lowers the enable just before the completing edge. It judges the result by requiring the flag to stay low, and by requiring a complete fresh entry delay after the rail is re-enabled. The second overlap is both rails reaching their thresholds at once with different delays. The bench judges this by checking that each rail's flag is released on its own edge.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

    localparam int unsigned NUM_RAILS = 2;

    typedef enum logic {
        RAIL_DOWN = 1'b0,
        RAIL_GOOD = 1'b1
    } rail_st_e;

    // microseconds to clock cycles for a given clock period in ns
    function automatic int unsigned us_to_cyc(input longint unsigned us,
                                              input int unsigned clk_ns);
        longint unsigned t;
        t = (us * 64'd1000) / longint'(clk_ns);
        return int'(t);
    endfunction

    function automatic int unsigned at_least(input int unsigned v,
                                             input int unsigned floor_v);
        return (v < floor_v) ? floor_v : v;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pgr_delay_cfg.sv
module pgr_delay_cfg
    import pgr_pkg::*;
#(
    parameter int unsigned CFG_W         = 8,
    parameter int unsigned CNT_W         = 32,
    parameter int unsigned CLK_PERIOD_NS = 1000,
    parameter int unsigned R2_RATIO      = 8000,
    parameter int unsigned R2_RESET_VAL  = 25,
    parameter int unsigned MIN_CYC       = 10
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_val_i,
    output logic [CNT_W-1:0] entry_dly_o,
    output logic [CNT_W-1:0] exit_dly_o
);

    localparam int unsigned EXIT_SCALE  = us_to_cyc(1, CLK_PERIOD_NS);
    localparam int unsigned ENTRY_SCALE = us_to_cyc(longint'(R2_RATIO), CLK_PERIOD_NS);

    logic [CFG_W-1:0] prog_q;
    logic [CNT_W-1:0] prog_ext;
    logic [CNT_W-1:0] entry_raw;
    logic [CNT_W-1:0] exit_raw;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prog_q <= CFG_W'(R2_RESET_VAL);
        end else if (cfg_we_i) begin
            prog_q <= cfg_val_i;
        end
    end

    always_comb begin
        prog_ext  = CNT_W'(prog_q);
        entry_raw = prog_ext * CNT_W'(ENTRY_SCALE);
        exit_raw  = prog_ext * CNT_W'(EXIT_SCALE);
        entry_dly_o = (entry_raw < CNT_W'(MIN_CYC)) ? CNT_W'(MIN_CYC) : entry_raw;
        exit_dly_o  = (exit_raw  < CNT_W'(MIN_CYC)) ? CNT_W'(MIN_CYC) : exit_raw;
    end

endmodule

// File: rtl/pgr_rail_filter.sv
module pgr_rail_filter
    import pgr_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             above_hi_i,
    input  logic             below_lo_i,
    input  logic [CNT_W-1:0] entry_dly_i,
    input  logic [CNT_W-1:0] exit_dly_i,
    output logic             good_o
);

    typedef struct packed {
        rail_st_e         st;
        logic [CNT_W-1:0] cnt;
    } rail_q_t;

    rail_q_t q, d;
    logic    qual;
    logic [CNT_W-1:0] limit;

    always_comb begin
        // one timer per rail: the state decides which input it qualifies
        qual  = (q.st == RAIL_GOOD) ? below_lo_i : above_hi_i;
        limit = (q.st == RAIL_GOOD) ? exit_dly_i : entry_dly_i;
        d     = q;
        if (!qual) begin
            d.cnt = '0;
        end else if (q.cnt >= limit - 1'b1) begin
            d.st  = (q.st == RAIL_GOOD) ? RAIL_DOWN : RAIL_GOOD;
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            q.st  <= RAIL_DOWN;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign good_o = (q.st == RAIL_GOOD);

endmodule

// File: rtl/pgr_reset_gen.sv
module pgr_reset_gen
    import pgr_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 1000,
    parameter int unsigned R1_ENTRY_US   = 2000,
    parameter int unsigned R1_EXIT_US    = 25,
    parameter int unsigned MIN_EXIT_US   = 10,
    parameter int unsigned R2_RATIO      = 8000,
    parameter int unsigned R2_RESET_VAL  = 25,
    parameter int unsigned CFG_W         = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [1:0]       rail_en_i,
    input  logic [1:0]       above_hi_i,
    input  logic [1:0]       below_lo_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_val_i,
    output logic [1:0]       rst_n_o
);

    localparam int unsigned MIN_CYC      = at_least(us_to_cyc(MIN_EXIT_US, CLK_PERIOD_NS), 1);
    localparam int unsigned R1_ENTRY_CYC = at_least(us_to_cyc(R1_ENTRY_US, CLK_PERIOD_NS), MIN_CYC);
    localparam int unsigned R1_EXIT_CYC  = at_least(us_to_cyc(R1_EXIT_US, CLK_PERIOD_NS), MIN_CYC);
    localparam int unsigned R2_MAX_CYC   =
        us_to_cyc(longint'((2 ** CFG_W) - 1) * longint'(R2_RATIO), CLK_PERIOD_NS);
    localparam int unsigned CNT_W =
        $clog2(max3(R1_ENTRY_CYC, R2_MAX_CYC, MIN_CYC) + 1);

    logic [CNT_W-1:0] entry_dly [NUM_RAILS];
    logic [CNT_W-1:0] exit_dly  [NUM_RAILS];
    logic [CNT_W-1:0] r2_entry;
    logic [CNT_W-1:0] r2_exit;

    pgr_delay_cfg #(
        .CFG_W         (CFG_W),
        .CNT_W         (CNT_W),
        .CLK_PERIOD_NS (CLK_PERIOD_NS),
        .R2_RATIO      (R2_RATIO),
        .R2_RESET_VAL  (R2_RESET_VAL),
        .MIN_CYC       (MIN_CYC)
    ) u_cfg (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_val_i   (cfg_val_i),
        .entry_dly_o (r2_entry),
        .exit_dly_o  (r2_exit)
    );

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        if (g == 0) begin : g_fixed
            assign entry_dly[g] = CNT_W'(R1_ENTRY_CYC);
            assign exit_dly[g]  = CNT_W'(R1_EXIT_CYC);
        end else begin : g_prog
            assign entry_dly[g] = r2_entry;
            assign exit_dly[g]  = r2_exit;
        end

        pgr_rail_filter #(
            .CNT_W (CNT_W)
        ) u_filt (
            .clk_i       (clk_i),
            .rst_i       (rst_i),
            .en_i        (rail_en_i[g]),
            .above_hi_i  (above_hi_i[g]),
            .below_lo_i  (below_lo_i[g]),
            .entry_dly_i (entry_dly[g]),
            .exit_dly_i  (exit_dly[g]),
            .good_o      (rst_n_o[g])
        );
    end

endmodule

// File: rtl/pgr_reset_gen_chk.sv
module pgr_reset_gen_chk
    import pgr_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 1000,
    parameter int unsigned R1_ENTRY_US   = 2000,
    parameter int unsigned R1_EXIT_US    = 25,
    parameter int unsigned MIN_EXIT_US   = 10
) (
    input logic       clk_i,
    input logic       rst_i,
    input logic [1:0] rail_en_i,
    input logic [1:0] above_hi_i,
    input logic [1:0] below_lo_i,
    input logic [1:0] rst_n_o
);

    localparam int unsigned MIN_C   = at_least(us_to_cyc(MIN_EXIT_US, CLK_PERIOD_NS), 1);
    localparam int unsigned ENTRY_C = at_least(us_to_cyc(R1_ENTRY_US, CLK_PERIOD_NS), MIN_C);
    localparam int unsigned EXIT_C  = at_least(us_to_cyc(R1_EXIT_US, CLK_PERIOD_NS), MIN_C);

    // consecutive-sample run lengths of rail 1 comparator inputs
    logic [31:0] above_run;
    logic [31:0] below_run;

    always_ff @(posedge clk_i) begin
        if (rst_i || !rail_en_i[0]) begin
            above_run <= '0;
            below_run <= '0;
        end else begin
            above_run <= above_hi_i[0] ? ((above_run == 32'hFFFF_FFFF) ? above_run : above_run + 1) : '0;
            below_run <= below_lo_i[0] ? ((below_run == 32'hFFFF_FFFF) ? below_run : below_run + 1) : '0;
        end
    end

    p_entry_len_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(rst_n_o[0]) |-> (above_run >= ENTRY_C));

    p_exit_len_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(rst_n_o[0]) && $past(rail_en_i[0])) |-> (below_run >= EXIT_C));

    p_dis_rail1_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        !rail_en_i[0] |=> !rst_n_o[0]);

    p_dis_rail2_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        !rail_en_i[1] |=> !rst_n_o[1]);

    p_rail2_entry_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(rst_n_o[1]) |-> ($past(above_hi_i[1]) && $past(rail_en_i[1])));

    p_rail2_exit_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(rst_n_o[1]) && $past(rail_en_i[1])) |-> $past(below_lo_i[1]));

endmodule

bind pgr_reset_gen pgr_reset_gen_chk #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .R1_ENTRY_US   (R1_ENTRY_US),
    .R1_EXIT_US    (R1_EXIT_US),
    .MIN_EXIT_US   (MIN_EXIT_US)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .rail_en_i  (rail_en_i),
    .above_hi_i (above_hi_i),
    .below_lo_i (below_lo_i),
    .rst_n_o    (rst_n_o)
);

// File: tb/pgr_reset_gen_tb.sv
module pgr_reset_gen_tb;

    localparam int unsigned RATIO = 400;
    localparam int E1 = 2000;
    localparam int X1 = 25;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] en;
    logic [1:0] above;
    logic [1:0] below;
    logic       cfg_we;
    logic [7:0] cfg_val;
    logic [1:0] rst_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pgr_reset_gen #(.R2_RATIO(RATIO)) u_dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .rail_en_i  (en),
        .above_hi_i (above),
        .below_lo_i (below),
        .cfg_we_i   (cfg_we),
        .cfg_val_i  (cfg_val),
        .rst_n_o    (rst_n)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [1:0] exp);
        checks++;
        if (rst_n !== exp) begin
            fails++;
            $display("FAIL %s: rst_n_o actual=%b expected=%b at %0t", req, rst_n, exp, $time);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        cfg_val = v;
        cfg_we  = 1'b1;
        step(1);
        cfg_we  = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; en = 2'b11; above = 2'b00; below = 2'b00;
        cfg_we = 1'b0; cfg_val = '0;
        step(3);
        chk("R1 in reset", 2'b00);
        rst = 1'b0;
        step(2);
        chk("R1 after reset", 2'b00);
    endtask

    task automatic t_r1_entry_exit();
        above[0] = 1'b1;
        step(E1 - 1); chk("R2 one short", 2'b00);
        step(1);      chk("R2 entry", 2'b01);
        above[0] = 1'b0; below[0] = 1'b1;
        step(X1 - 1);
        below[0] = 1'b0;
        step(1);      chk("R4 short dip rejected", 2'b01);
        below[0] = 1'b1;
        step(X1 - 1); chk("R5 exit restarted", 2'b01);
        step(1);      chk("R4 exit", 2'b00);
        below[0] = 1'b0;
    endtask

    task automatic t_entry_restart();
        above[0] = 1'b1;
        step(E1 - 1);
        above[0] = 1'b0;
        step(1);      chk("R3 glitch rejected", 2'b00);
        above[0] = 1'b1;
        step(E1 - 1); chk("R3 entry restarted", 2'b00);
        step(1);      chk("R2 entry after restart", 2'b01);
        above[0] = 1'b0; below[0] = 1'b1;
        step(X1);     chk("R4 exit again", 2'b00);
        below[0] = 1'b0;
    endtask

    task automatic t_rail2_prog();
        write_cfg(8'd12);
        above[1] = 1'b1;
        step(12 * RATIO - 1); chk("R6 entry one short", 2'b00);
        step(1);              chk("R6 entry, R8 rail1 untouched", 2'b10);
        above[1] = 1'b0; below[1] = 1'b1;
        step(11);             chk("R6 exit one short", 2'b10);
        step(1);              chk("R6 exit", 2'b00);
        below[1] = 1'b0;
    endtask

    task automatic t_clamp();
        write_cfg(8'd3);
        above[1] = 1'b1;
        step(3 * RATIO - 1); chk("R6 scaled entry short", 2'b00);
        step(1);             chk("R6 scaled entry", 2'b10);
        above[1] = 1'b0; below[1] = 1'b1;
        step(9);             chk("R7 exit clamped short", 2'b10);
        step(1);             chk("R7 exit clamped to 10", 2'b00);
        below[1] = 1'b0;
        write_cfg(8'd0);
        above[1] = 1'b1;
        step(9);             chk("R7 entry clamped short", 2'b00);
        step(1);             chk("R7 entry clamped to 10", 2'b10);
        above[1] = 1'b0; below[1] = 1'b1;
        step(9);             chk("R7 zero exit short", 2'b10);
        step(1);             chk("R7 zero exit", 2'b00);
        below[1] = 1'b0;
    endtask

    task automatic t_indep();
        write_cfg(8'd12);
        above = 2'b11;
        step(E1 - 1);              chk("R8 both pending", 2'b00);
        step(1);                   chk("R8 rail1 first", 2'b01);
        step(12 * RATIO - E1 - 1); chk("R8 rail2 pending", 2'b01);
        step(1);                   chk("R8 both good", 2'b11);
        above[0] = 1'b0; below[0] = 1'b1;
        step(X1);                  chk("R8 rail1 exit alone", 2'b10);
        below[0] = 1'b0;
    endtask

    task automatic t_enable();
        above[0] = 1'b1;
        step(E1 - 1);
        en[0] = 1'b0;
        step(1);      chk("R9 enable wins at expiry", 2'b10);
        en[0] = 1'b1;
        step(E1 - 1); chk("R1 timer cleared", 2'b10);
        step(1);      chk("R1 full delay after enable", 2'b11);
        en[0] = 1'b0;
        step(1);      chk("R1 disable forces low", 2'b10);
        en[0] = 1'b1;
        en[1] = 1'b0;
        step(1);      chk("R1 rail2 disable", 2'b00);
    endtask

    initial begin
        t_reset();
        t_r1_entry_exit();
        t_entry_restart();
        t_rail2_prog();
        t_clamp();
        t_indep();
        t_enable();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule